// File: doc/BRIEF.md
# ADC Serial Command and Data Port

This block is the digital slave port of a two-channel, 8-bit sampling converter. A host lowers chip select and toggles a serial clock. The port then watches the data-in line for a start bit and reads a three-bit command after it. It decodes that command into an input route for the analog front end. It opens a sample window, fires a start-of-conversion strobe, and shifts the converter's result out on a tri-stateable data-out line. The result arrives on a parallel input that stands in for the successive-approximation core.

All pins are treated as synchronous to the system clock `clk`. Serial clock edges are found by comparing the current `sck` level with a registered copy. Each serial-clock edge therefore acts on the first `clk` rising edge that sees the new level. Two state machines do the work. The front machine has the states F_IDLE, F_HUNT, F_CMD and F_LOCKED. Its transitions are:
- F_IDLE to F_HUNT when chip select is low.
- F_HUNT to F_CMD on a rising edge that samples a one.
- F_CMD to F_LOCKED on the rising edge that takes the last command bit.
- Any state to F_IDLE while chip select is high.

The back machine has the states B_OFF, B_MSB, B_LSB and B_ZERO. Its transitions are:
- B_OFF to B_MSB on the first falling edge while the front is locked.
- B_MSB to B_ZERO or B_LSB on the falling edge that drives the lowest result bit.
- B_LSB to B_ZERO on the falling edge that drives the top bit again.
- Any state to B_OFF while chip select is high.

Top module: `adc_sport`

## Requirements
- R1: While `cs_n` is high, `pwr_down`=1, `sdo_oe`=0 and `sdo`=0, and both machines return to their idle states from any state. A transaction cut short this way leaves no trace on the next one.
- R2: After `cs_n` falls, `sdi` is sampled on rising `sck` edges. The first one sampled is the start bit, and any zeros before it are ignored.
- R3: The three bits after the start bit form the command, in this order: bit 0 is single-ended select, bit 1 is odd/sign select, bit 2 is MSB-only select.
- R4: Route decode. `pos_sel` 0 means CH0 and 1 means CH1. `neg_sel` 00 means ground, 01 means CH0 and 10 means CH1. Single=1 gives positive = odd with ground as negative. Single=0 and odd=0 gives CH0 against CH1. Single=0 and odd=1 gives CH1 against CH0. `mux_valid` rises together with the route.
- R5: Once the command is complete, `sdi` has no effect until `cs_n` has gone high and low again.
- R6: `sample_win` rises on the rising edge that captures the odd/sign bit. It falls on the falling edge after the next rising edge, which makes the window 1.5 `sck` periods long.
- R7: On the falling edge that closes the window, `conv_start` pulses for one `clk` cycle and `result_i` is latched. `conv_busy` is high from that edge until the falling edge that drives B0, which is 8 `sck` periods.
- R8: `sdo` changes only on falling `sck` edges or when deselected. On the window-closing edge `sdo_oe` rises and a null bit (0) is driven. After that come B7 down to B0, one bit per falling edge.
- R9: With MSB-only select = 1, `sdo` is 0 on every falling edge after B0.
- R10: With MSB-only select = 0, B1 through B7 follow B0, so B0 is not repeated. Zeros follow after that.
- R11: Changes on `result_i` after the latch edge do not affect the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Host serial clock level |
| sdi | input | 1 | Serial data in (start bit and command) |
| result_i | input | DATA_W | Conversion result from the converter core |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the data-out pad driver |
| pwr_down | output | 1 | Power-down flag, high while deselected |
| sample_win | output | 1 | Analog sample window |
| conv_start | output | 1 | One-cycle start-of-conversion strobe |
| conv_busy | output | 1 | Conversion in progress |
| mux_valid | output | 1 | Route outputs are valid |
| pos_sel | output | 1 | Positive input channel |
| neg_sel | output | 2 | Negative input: ground, CH0 or CH1 |

## Verification
The assertions check several rules on every cycle. The pad is quiet and disabled whenever the port is powered down. The sample window and the busy flag never overlap. The decoded route never pairs a channel with itself. The start strobe is a single pulse. Data-out moves only on a falling serial edge, and no leading zero moves the front machine out of hunting. Only the bench scenarios can show the full sequence for each command: the exact serial bit stream, including the shared B0 and the zero fill. They also show the 1.5-period window, the 8-period busy span, that the result is latched at the right edge, and that an aborted transaction leaves the next one clean.

// File: rtl/adc_sport_pkg.sv
`timescale 1ns/1ps
package adc_sport_pkg;

    typedef enum logic [1:0] {
        F_IDLE,
        F_HUNT,
        F_CMD,
        F_LOCKED
    } front_state_t;

    typedef enum logic [1:0] {
        B_OFF,
        B_MSB,
        B_LSB,
        B_ZERO
    } back_state_t;

    localparam logic [1:0] NEG_GND = 2'b00;
    localparam logic [1:0] NEG_CH0 = 2'b01;
    localparam logic [1:0] NEG_CH1 = 2'b10;

    typedef struct packed {
        logic       pos;
        logic [1:0] neg;
    } mux_route_t;

    // positive side follows odd/sign; negative is ground or the other channel
    function automatic mux_route_t decode_route(input logic single, input logic odd);
        mux_route_t r;
        r.pos = odd;
        if (single) r.neg = NEG_GND;
        else        r.neg = odd ? NEG_CH0 : NEG_CH1;
        return r;
    endfunction

endpackage

// File: rtl/adc_sport_edge.sv
`timescale 1ns/1ps
module adc_sport_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

endmodule

// File: rtl/adc_sport_front.sv
`timescale 1ns/1ps
module adc_sport_front
    import adc_sport_pkg::*;
#(
    parameter int CMD_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sdi,
    input  logic       sck_rise,
    input  logic       sck_fall,
    output logic       pwr_down,
    output logic       locked,
    output logic       msbf,
    output logic       sample_win,
    output logic       mux_valid,
    output logic       pos_sel,
    output logic [1:0] neg_sel
);
    localparam int CNT_W    = (CMD_W > 1) ? $clog2(CMD_W) + 1 : 1;
    localparam int SGL_POS  = 0;
    localparam int ODD_POS  = 1;
    localparam int MSBF_POS = 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

    front_state_t     state_q, state_d;
    logic [CMD_W-1:0] cmd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             win_q, valid_q;
    mux_route_t       route;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_IDLE:   if (!cs_n) state_d = F_HUNT;
            F_HUNT:   if (sck_rise && sdi) state_d = F_CMD;
            F_CMD:    if (sck_rise && cnt_q == LAST) state_d = F_LOCKED;
            F_LOCKED: state_d = F_LOCKED;
            default:  state_d = F_IDLE;
        endcase
        if (cs_n) state_d = F_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= F_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            cnt_q   <= '0;
            win_q   <= 1'b0;
            valid_q <= 1'b0;
        end else if (cs_n) begin
            cmd_q   <= '0;
            cnt_q   <= '0;
            win_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            if (state_q == F_HUNT && sck_rise && sdi) cnt_q <= '0;
            if (state_q == F_CMD && sck_rise) begin
                for (int i = 0; i < CMD_W; i++) begin
                    if (cnt_q == CNT_W'(i)) cmd_q[i] <= sdi;
                end
                cnt_q <= cnt_q + CNT_W'(1);
                if (cnt_q == CNT_W'(ODD_POS)) begin
                    win_q   <= 1'b1;
                    valid_q <= 1'b1;
                end
            end
            if (state_q == F_LOCKED && sck_fall) win_q <= 1'b0;
        end
    end

    assign route      = decode_route(cmd_q[SGL_POS], cmd_q[ODD_POS]);
    assign pwr_down   = (state_q == F_IDLE);
    assign locked     = (state_q == F_LOCKED);
    assign msbf       = cmd_q[MSBF_POS];
    assign sample_win = win_q;
    assign mux_valid  = valid_q;
    assign pos_sel    = valid_q ? route.pos : 1'b0;
    assign neg_sel    = valid_q ? route.neg : NEG_GND;

    // R2
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F_HUNT && sck_rise && !sdi && !cs_n) |=> (state_q == F_HUNT));

    // R5
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F_LOCKED && !cs_n) |=> $stable(cmd_q));

endmodule

// File: rtl/adc_sport_back.sv
`timescale 1ns/1ps
module adc_sport_back
    import adc_sport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_fall,
    input  logic              locked,
    input  logic              msbf,
    input  logic [DATA_W-1:0] result_i,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              conv_start,
    output logic              conv_busy
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(DATA_W - 1);

    back_state_t       state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic [IDX_W-1:0]  idx_q;
    logic              sdo_q, oe_q, start_q, busy_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_OFF:   if (sck_fall && locked) state_d = B_MSB;
            B_MSB:   if (sck_fall && idx_q == '0) state_d = msbf ? B_ZERO : B_LSB;
            B_LSB:   if (sck_fall && idx_q == TOP) state_d = B_ZERO;
            B_ZERO:  state_d = B_ZERO;
            default: state_d = B_OFF;
        endcase
        if (cs_n) state_d = B_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= B_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            idx_q   <= '0;
            sdo_q   <= 1'b0;
            oe_q    <= 1'b0;
            start_q <= 1'b0;
            busy_q  <= 1'b0;
        end else if (cs_n) begin
            idx_q   <= '0;
            sdo_q   <= 1'b0;
            oe_q    <= 1'b0;
            start_q <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (sck_fall) begin
                unique case (state_q)
                    B_OFF: begin
                        if (locked) begin
                            sdo_q   <= 1'b0;
                            oe_q    <= 1'b1;
                            data_q  <= result_i;
                            start_q <= 1'b1;
                            busy_q  <= 1'b1;
                            idx_q   <= TOP;
                        end
                    end
                    B_MSB: begin
                        sdo_q <= data_q[idx_q];
                        if (idx_q == '0) begin
                            busy_q <= 1'b0;
                            idx_q  <= IDX_W'(1);
                        end else begin
                            idx_q <= idx_q - IDX_W'(1);
                        end
                    end
                    B_LSB: begin
                        sdo_q <= data_q[idx_q];
                        idx_q <= idx_q + IDX_W'(1);
                    end
                    B_ZERO:  sdo_q <= 1'b0;
                    default: sdo_q <= 1'b0;
                endcase
            end
        end
    end

    assign sdo        = sdo_q;
    assign sdo_oe     = oe_q;
    assign conv_start = start_q;
    assign conv_busy  = busy_q;

    // R7
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R8
    oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(sck_fall));

    // R8
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> ($past(sck_fall) || $past(cs_n)));

    // R9
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == B_ZERO && sck_fall && !cs_n) |=> !sdo);

endmodule

// File: rtl/adc_sport.sv
`timescale 1ns/1ps
module adc_sport
    import adc_sport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CMD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic [DATA_W-1:0] result_i,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              pwr_down,
    output logic              sample_win,
    output logic              conv_start,
    output logic              conv_busy,
    output logic              mux_valid,
    output logic              pos_sel,
    output logic [1:0]        neg_sel
);
    logic sck_rise, sck_fall, locked, msbf;

    adc_sport_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sck),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    adc_sport_front #(.CMD_W(CMD_W)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .pwr_down  (pwr_down),
        .locked    (locked),
        .msbf      (msbf),
        .sample_win(sample_win),
        .mux_valid (mux_valid),
        .pos_sel   (pos_sel),
        .neg_sel   (neg_sel)
    );

    adc_sport_back #(.DATA_W(DATA_W)) u_back (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck_fall  (sck_fall),
        .locked    (locked),
        .msbf      (msbf),
        .result_i  (result_i),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .conv_start(conv_start),
        .conv_busy (conv_busy)
    );

    // R1
    pwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (!sdo_oe && !sdo));

    // R6
    win_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_win && conv_busy));

    // R4
    route_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mux_valid |-> (neg_sel != 2'b11 && neg_sel != (pos_sel ? NEG_CH1 : NEG_CH0)));

endmodule

// File: tb/sim_adc_sport.sv
`timescale 1ns/1ps
module sim_adc_sport;

    logic       clk = 1'b0;
    logic       rst_n, cs_n, sck, sdi;
    logic [7:0] result_i;
    logic       sdo, sdo_oe, pwr_down, sample_win, conv_start, conv_busy;
    logic       mux_valid, pos_sel;
    logic [1:0] neg_sel;

    always #2.5 clk = ~clk;

    adc_sport u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .result_i(result_i), .sdo(sdo), .sdo_oe(sdo_oe), .pwr_down(pwr_down),
        .sample_win(sample_win), .conv_start(conv_start), .conv_busy(conv_busy),
        .mux_valid(mux_valid), .pos_sel(pos_sel), .neg_sel(neg_sel)
    );

    int total = 0;
    int bad   = 0;
    int starts = 0;
    bit finished = 1'b0;

    logic hi_win, hi_sdo, lo_sdo, lo_win, lo_oe, lo_busy;

    // vector: {lead_zeros[1:0], single, odd, msb_only, result[7:0]}
    localparam int NV = 6;
    localparam logic [12:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b0, 1'b1, 8'hA5},
        {2'd2, 1'b1, 1'b1, 1'b0, 8'h3C},
        {2'd1, 1'b0, 1'b0, 1'b1, 8'h81},
        {2'd3, 1'b0, 1'b1, 1'b0, 8'h96},
        {2'd0, 1'b0, 1'b0, 1'b0, 8'h01},
        {2'd2, 1'b1, 1'b1, 1'b1, 8'hFF}
    };

    always @(negedge clk) if (rst_n && conv_start) starts++;

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic tick(input logic d);
        @(negedge clk); sdi = d;
        repeat (3) @(negedge clk); sck = 1'b1;
        repeat (2) @(negedge clk); hi_win = sample_win; hi_sdo = sdo;
        repeat (2) @(negedge clk); sck = 1'b0;
        repeat (2) @(negedge clk);
        lo_sdo = sdo; lo_win = sample_win; lo_oe = sdo_oe; lo_busy = conv_busy;
    endtask

    function automatic logic [19:0] exp_stream(input logic [7:0] r, input bit msb_only);
        logic [19:0] s = '0;
        for (int k = 0; k < 8; k++) s[k] = r[7-k];
        if (!msb_only) for (int k = 8; k < 15; k++) s[k] = r[k-7];
        return s;
    endfunction

    task automatic deselect();
        @(negedge clk); cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(pwr_down && !sdo_oe && !sdo && !conv_busy && !sample_win,
            "R1 deselect quiets port", {pwr_down, sdo_oe, sdo, conv_busy, sample_win}, 5'b10000);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_txn(input int lead, input bit sgl, input bit odd, input bit msb_only,
                           input logic [7:0] res);
        int c0;
        logic [19:0] got, exp;
        logic [1:0] eneg;
        bit edge_ok, b6, b7, prev;
        got = '0;
        eneg = sgl ? 2'b00 : (odd ? 2'b01 : 2'b10);
        @(negedge clk); cs_n = 1'b0; result_i = res;
        repeat (3) @(negedge clk);
        chk(!pwr_down, "R1 power-down released when selected", pwr_down, 0);
        for (int i = 0; i < lead; i++) tick(1'b0);
        tick(1'b1);
        tick(sgl);
        chk(!hi_win && !mux_valid, "R6 window closed before odd bit", {hi_win, mux_valid}, 0);
        tick(odd);
        chk(hi_win && lo_win, "R6 window opens on odd bit", {hi_win, lo_win}, 3);
        chk(mux_valid && pos_sel == odd && neg_sel == eneg, "R2 R3 R4 route decode",
            {mux_valid, pos_sel, neg_sel}, {1'b1, odd, eneg});
        c0 = starts;
        tick(msb_only);
        chk(hi_win, "R6 window spans last command rise", hi_win, 1);
        chk(!lo_win && lo_oe && !lo_sdo, "R8 null bit and enable at window close",
            {lo_win, lo_oe, lo_sdo}, 3'b010);
        chk(starts == c0 + 1 && lo_busy, "R7 single start strobe and busy", starts - c0, 1);
        result_i = ~res;
        edge_ok = 1'b1; b6 = 1'b0; b7 = 1'b1;
        for (int k = 0; k < 20; k++) begin
            prev = lo_sdo;
            tick(1'b1);
            if (hi_sdo !== prev) edge_ok = 1'b0;
            got[k] = lo_sdo;
            if (k == 6) b6 = lo_busy;
            if (k == 7) b7 = lo_busy;
        end
        exp = exp_stream(res, msb_only);
        chk(b6 && !b7, "R7 busy spans eight periods", {b6, b7}, 2'b10);
        chk(edge_ok, "R8 data-out steady while clock high", edge_ok, 1);
        chk(got == exp, msb_only ? "R9 R11 R5 stream msb-only" : "R10 R11 R5 stream with lsb copy",
            got, exp);
        chk(pos_sel == odd && neg_sel == eneg && starts == c0 + 1, "R5 command held after lock",
            {pos_sel, neg_sel}, {odd, eneg});
        deselect();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; result_i = '0;
        repeat (4) @(negedge clk);
        chk(pwr_down && !sdo_oe && !sdo && !sample_win && !conv_busy && !mux_valid,
            "R1 reset state", {pwr_down, sdo_oe, sdo, sample_win, conv_busy, mux_valid}, 6'b100000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < NV; v++)
            run_txn(int'(VEC[v][12:11]), VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0]);

        // R1 abort during command capture, then a clean transaction
        @(negedge clk); cs_n = 1'b0;
        tick(1'b1); tick(1'b0);
        deselect();
        run_txn(1, 1'b0, 1'b1, 1'b0, 8'h5A);

        // R1 abort during output shifting, then a clean transaction
        @(negedge clk); cs_n = 1'b0; result_i = 8'hC3;
        tick(1'b1); tick(1'b1); tick(1'b0); tick(1'b0);
        tick(1'b1); tick(1'b1);
        chk(conv_busy && sdo_oe, "R7 busy mid-output before abort", {conv_busy, sdo_oe}, 3);
        deselect();
        run_txn(0, 1'b1, 1'b0, 1'b0, 8'h7E);

        // R2 only zeros: nothing starts
        @(negedge clk); cs_n = 1'b0;
        for (int i = 0; i < 6; i++) tick(1'b0);
        chk(!mux_valid && !sdo_oe && starts == 9, "R2 zeros alone never start",
            {mux_valid, sdo_oe}, 0);
        deselect();

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule